// File: doc/BRIEF.md
# Headphone Jack Sensing and Amplifier Protection Controller

This block makes the final power-enable decision for three headphone-side amplifiers and two speaker channels. It takes a raw plug-sense pin, per-output short-circuit flags from the headphone drivers, per-channel over-temperature flags from the speaker drivers, and the enable requests held in control registers. From these it drives the enable lines of each amplifier and presents status bits for software to read.

The plug-sense pin is synchronized and debounced. A polarity control picks which debounced level means "plug present". In automatic mode, an inserted plug routes audio to the headphone amplifiers and silences the speakers; removing it does the reverse. In manual mode only the register requests count. The common/mono headphone output can be excluded from automatic routing. A short on an enabled headphone output switches off only that output and latches it off until software re-requests it. Over-temperature on an enabled speaker channel switches off every amplifier until that channel's latch is released.

Top module: `amp_guard_ctrl`

## Requirements
- R1: The plug pin passes through two synchronizing flops and a debounce counter of DB_CYCLES = CLK_KHZ*DEBOUNCE_MS clocks; a pin change is reflected on the clock edge DB_CYCLES+2 after it, and a pulse shorter than DB_CYCLES clocks is ignored.
- R2: plug_stat_o equals the debounced pin level XOR plug_pol_i; 1 means a plug is present. The debounced level is 0 after reset.
- R3: With auto_en_i=1, headphone outputs follow hp_en_req_i only while a plug is present, and speaker outputs follow spk_en_req_i only while no plug is present.
- R4: With auto_en_i=0, hp_pwr_o and spk_pwr_o follow the requests regardless of plug state.
- R5: With mono_exempt_i=1, the common/mono output (hp bit 2; bit 0 is left, bit 1 right) follows its request in automatic mode regardless of plug state.
- R6: A short flag on an enabled headphone output turns that output off from the next clock edge and sets its bit in hp_short_stat_o; other outputs are unaffected.
- R7: A latched short clears on the edge after that output's request goes from 0 to 1, and the output turns back on from that edge.
- R8: An over-temperature flag on an enabled speaker channel (bit 0 left, bit 1 right) turns off all headphone and speaker outputs from the next edge and sets that channel's bit in thermal_stat_o.
- R9: A thermal latch holds until its own channel's release input is high at a clock edge; the other channel's release has no effect on it.
- R10: Short and over-temperature flags on outputs that are not enabled set no status and change no output.
- R11: After reset all outputs and status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| plug_pin_i | input | 1 | Raw plug-sense pin |
| plug_pol_i | input | 1 | Inverts the meaning of the debounced pin |
| auto_en_i | input | 1 | Automatic plug-driven routing enable |
| mono_exempt_i | input | 1 | Excludes common/mono output from routing |
| hp_en_req_i | input | 3 | Headphone enable requests (L, R, common) |
| spk_en_req_i | input | 2 | Speaker enable requests (L, R) |
| hp_short_i | input | 3 | Short-circuit flags per headphone output |
| spk_hot_i | input | 2 | Over-temperature flags per speaker channel |
| thermal_release_i | input | 2 | Per-channel thermal latch release |
| hp_pwr_o | output | 3 | Headphone amplifier power enables |
| spk_pwr_o | output | 2 | Speaker amplifier power enables |
| plug_stat_o | output | 1 | Plug present status |
| hp_short_stat_o | output | 3 | Latched short status per output |
| thermal_stat_o | output | 2 | Latched thermal status per channel |

## Verification
A stuck or missed fault latch shows at the ports within one clock: the output stays on after its short flag, or the status bit stays clear, or every amplifier fails to drop after an over-temperature flag. A wrong debounce count or polarity shows as plug_stat_o changing an edge early or late, or on a glitch, and then as the wrong amplifier set switching in automatic mode in the same cycle. A missing edge detector on the re-request shows as an output that never returns after a short.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;
  localparam int HP_N       = 3;
  localparam int SPK_N      = 2;
  localparam int HP_COM_IDX = 2;
endpackage

// File: rtl/plug_debounce.sv
module plug_debounce #(
  parameter int DB_CYCLES = 196608
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o
);
  localparam int CW = $clog2(DB_CYCLES + 1);

  logic          sync_q1, sync_q2;
  logic          lvl_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q1 <= 1'b0;
      sync_q2 <= 1'b0;
    end else begin
      sync_q1 <= pin_i;
      sync_q2 <= sync_q1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else if (sync_q2 == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DB_CYCLES - 1)) begin
      lvl_q <= sync_q2;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = lvl_q;

  // R1
  db_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q2 == lvl_q) |=> $stable(lvl_q));
endmodule

// File: rtl/fault_latch.sv
module fault_latch #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] lat_o
);
  logic [N-1:0] lat_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lat_q[i] <= 1'b0;
      else if (clr_i[i]) lat_q[i] <= 1'b0;
      else if (set_i[i]) lat_q[i] <= 1'b1;
    end
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/route_policy.sv
module route_policy
  import amp_guard_pkg::*;
(
  input  logic             present_i,
  input  logic             auto_i,
  input  logic             exempt_i,
  input  logic [HP_N-1:0]  hp_req_i,
  input  logic [SPK_N-1:0] spk_req_i,
  output logic [HP_N-1:0]  hp_gate_o,
  output logic [SPK_N-1:0] spk_gate_o
);
  for (genvar i = 0; i < HP_N; i++) begin : g_hp
    if (i == HP_COM_IDX) begin : g_com
      assign hp_gate_o[i] = hp_req_i[i] & (~auto_i | exempt_i | present_i);
    end else begin : g_side
      assign hp_gate_o[i] = hp_req_i[i] & (~auto_i | present_i);
    end
  end

  assign spk_gate_o = spk_req_i & {SPK_N{~auto_i | ~present_i}};
endmodule

// File: rtl/amp_guard_ctrl.sv
module amp_guard_ctrl
  import amp_guard_pkg::*;
#(
  parameter int CLK_KHZ     = 12288,
  parameter int DEBOUNCE_MS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             plug_pin_i,
  input  logic             plug_pol_i,
  input  logic             auto_en_i,
  input  logic             mono_exempt_i,
  input  logic [HP_N-1:0]  hp_en_req_i,
  input  logic [SPK_N-1:0] spk_en_req_i,
  input  logic [HP_N-1:0]  hp_short_i,
  input  logic [SPK_N-1:0] spk_hot_i,
  input  logic [SPK_N-1:0] thermal_release_i,
  output logic [HP_N-1:0]  hp_pwr_o,
  output logic [SPK_N-1:0] spk_pwr_o,
  output logic             plug_stat_o,
  output logic [HP_N-1:0]  hp_short_stat_o,
  output logic [SPK_N-1:0] thermal_stat_o
);
  localparam int DB_CYCLES = CLK_KHZ * DEBOUNCE_MS;

  logic             lvl;
  logic             present;
  logic [HP_N-1:0]  hp_gate, hp_on, short_lat, short_set, short_clr, req_q;
  logic [SPK_N-1:0] spk_gate, spk_on, therm_lat, therm_set;
  logic             therm_any;

  plug_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(plug_pin_i), .level_o(lvl));

  assign present = lvl ^ plug_pol_i;

  route_policy u_pol (
    .present_i(present), .auto_i(auto_en_i), .exempt_i(mono_exempt_i),
    .hp_req_i(hp_en_req_i), .spk_req_i(spk_en_req_i),
    .hp_gate_o(hp_gate), .spk_gate_o(spk_gate));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= hp_en_req_i;
  end

  assign therm_any = |therm_lat;
  assign hp_on     = hp_gate & ~short_lat & {HP_N{~therm_any}};
  assign spk_on    = spk_gate & {SPK_N{~therm_any}};
  assign short_set = hp_short_i & hp_on;
  assign short_clr = hp_en_req_i & ~req_q;
  assign therm_set = spk_hot_i & spk_on;

  fault_latch #(.N(HP_N)) u_short (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(short_set), .clr_i(short_clr),
    .lat_o(short_lat));

  fault_latch #(.N(SPK_N)) u_therm (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(therm_set), .clr_i(thermal_release_i),
    .lat_o(therm_lat));

  assign hp_pwr_o        = hp_on;
  assign spk_pwr_o       = spk_on;
  assign plug_stat_o     = present;
  assign hp_short_stat_o = short_lat;
  assign thermal_stat_o  = therm_lat;

  for (genvar i = 0; i < HP_N; i++) begin : g_hp_chk
    // R6
    short_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hp_short_i[i] && hp_pwr_o[i]) |=> (!hp_pwr_o[i] && hp_short_stat_o[i]));
    // R10
    short_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hp_short_stat_o[i] && !hp_pwr_o[i] && !(hp_en_req_i[i] && !req_q[i]))
        |=> !hp_short_stat_o[i]);
  end

  for (genvar c = 0; c < SPK_N; c++) begin : g_spk_chk
    // R8
    therm_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (spk_hot_i[c] && spk_pwr_o[c] && !thermal_release_i[c])
        |=> (thermal_stat_o[c] && spk_pwr_o == '0 && hp_pwr_o == '0));
    // R9
    therm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (thermal_stat_o[c] && !thermal_release_i[c]) |=> thermal_stat_o[c]);
  end

  // R3
  auto_spk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_en_i && plug_stat_o) |-> (spk_pwr_o == '0));
  // R4
  manual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_en_i) |-> ((hp_pwr_o & ~hp_en_req_i) == '0 && (spk_pwr_o & ~spk_en_req_i) == '0));
endmodule

// File: tb/sim_amp_guard_ctrl.sv
module sim_amp_guard_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b0, pol = 1'b0, auto_en = 1'b0, exempt = 1'b0;
  logic [2:0] hp_req = '0, hp_short = '0, hp_pwr, short_stat;
  logic [1:0] spk_req = '0, spk_hot = '0, rel = '0, spk_pwr, therm_stat;
  logic       plug_stat;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] hp; logic [1:0] spk; logic st; logic [2:0] sh; logic [1:0] th;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  event sample_ev;

  always #4 clk = ~clk;

  amp_guard_ctrl #(.CLK_KHZ(4), .DEBOUNCE_MS(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .plug_pin_i(pin), .plug_pol_i(pol),
    .auto_en_i(auto_en), .mono_exempt_i(exempt), .hp_en_req_i(hp_req),
    .spk_en_req_i(spk_req), .hp_short_i(hp_short), .spk_hot_i(spk_hot),
    .thermal_release_i(rel), .hp_pwr_o(hp_pwr), .spk_pwr_o(spk_pwr),
    .plug_stat_o(plug_stat), .hp_short_stat_o(short_stat),
    .thermal_stat_o(therm_stat));

  // monitor
  initial forever begin
    @(sample_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (hp_pwr !== e.hp || spk_pwr !== e.spk || plug_stat !== e.st ||
          short_stat !== e.sh || therm_stat !== e.th) begin
        errors++;
        $display("FAIL %s: got hp=%b spk=%b st=%b sh=%b th=%b exp hp=%b spk=%b st=%b sh=%b th=%b",
                 e.tag, hp_pwr, spk_pwr, plug_stat, short_stat, therm_stat,
                 e.hp, e.spk, e.st, e.sh, e.th);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic expect_now(input logic [2:0] hp, input logic [1:0] spk, input logic st,
                            input logic [2:0] sh, input logic [1:0] th, input string tag);
    exp_t e;
    #1;
    e.hp = hp; e.spk = spk; e.st = st; e.sh = sh; e.th = th; e.tag = tag;
    exp_q.push_back(e);
    -> sample_ev;
    #0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_now(3'b000, 2'b00, 1'b0, 3'b000, 2'b00, "R11 reset");
    rst_n = 1'b1;
    tick(1);
    hp_req = 3'b111; spk_req = 2'b11;
    expect_now(3'b111, 2'b11, 1'b0, 3'b000, 2'b00, "R4 manual on");

    pin = 1'b1;
    tick(5);
    expect_now(3'b111, 2'b11, 1'b0, 3'b000, 2'b00, "R1 not yet debounced");
    tick(1);
    expect_now(3'b111, 2'b11, 1'b1, 3'b000, 2'b00, "R1 debounced at DB+2");

    pin = 1'b0;
    tick(2);
    pin = 1'b1;
    tick(10);
    expect_now(3'b111, 2'b11, 1'b1, 3'b000, 2'b00, "R1 glitch ignored");

    auto_en = 1'b1;
    expect_now(3'b111, 2'b00, 1'b1, 3'b000, 2'b00, "R3 plug present");
    pol = 1'b1;
    expect_now(3'b000, 2'b11, 1'b0, 3'b000, 2'b00, "R2 polarity inverts, R3 absent");
    exempt = 1'b1;
    expect_now(3'b100, 2'b11, 1'b0, 3'b000, 2'b00, "R5 mono exempt");
    pol = 1'b0; exempt = 1'b0;
    expect_now(3'b111, 2'b00, 1'b1, 3'b000, 2'b00, "R3 plug back");

    hp_short = 3'b001;
    tick(1);
    hp_short = 3'b000;
    expect_now(3'b110, 2'b00, 1'b1, 3'b001, 2'b00, "R6 short left only");
    tick(3);
    expect_now(3'b110, 2'b00, 1'b1, 3'b001, 2'b00, "R6 short latched");

    hp_req = 3'b101;
    hp_short = 3'b010;
    tick(1);
    hp_short = 3'b000;
    expect_now(3'b100, 2'b00, 1'b1, 3'b001, 2'b00, "R10 short on disabled");

    hp_req = 3'b100;
    tick(1);
    hp_req = 3'b111;
    expect_now(3'b110, 2'b00, 1'b1, 3'b001, 2'b00, "R7 before clear edge");
    tick(1);
    expect_now(3'b111, 2'b00, 1'b1, 3'b000, 2'b00, "R7 cleared by re-request");

    auto_en = 1'b0;
    spk_hot = 2'b10;
    tick(1);
    spk_hot = 2'b00;
    expect_now(3'b000, 2'b00, 1'b1, 3'b000, 2'b10, "R8 thermal all off");
    rel = 2'b01;
    tick(1);
    rel = 2'b00;
    expect_now(3'b000, 2'b00, 1'b1, 3'b000, 2'b10, "R9 wrong release");
    rel = 2'b10;
    tick(1);
    rel = 2'b00;
    expect_now(3'b111, 2'b11, 1'b1, 3'b000, 2'b00, "R9 released");

    spk_req = 2'b01;
    spk_hot = 2'b10;
    tick(1);
    spk_hot = 2'b00;
    expect_now(3'b111, 2'b01, 1'b1, 3'b000, 2'b00, "R10 thermal on disabled");

    pin = 1'b0;
    tick(6);
    expect_now(3'b111, 2'b01, 1'b0, 3'b000, 2'b00, "R1 removal debounced");

    tick(1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule